// File: doc/BRIEF.md
# Serial Configuration Register Bank with Deferred Update

This block is a write-only configuration port driven over three wires: a serial clock, a serial data line and a latch strobe. Each configuration word is 32 bits long. The word is shifted in most significant bit first. When the latch strobe rises, the word is written to one of six registers, chosen by its three lowest bits. All three serial wires are brought into the system clock domain through synchronisers, and edges are detected there.

Writes to registers 0, 3 and 5 take effect at once. Register 1 and a group of reference fields in register 2 go into shadow storage instead. They are released into the active copy only by the next write to register 0. The 3-bit output divider field of register 4 is held in the same way, but only while the hold-enable bit of the active register 2 is set. When that bit is clear, the field changes at once. A write to register 0 releases everything that is held in the same clock in which register 0 itself is loaded, and it raises a one-cycle commit pulse.

The active copies of all six registers are presented as one flat bus. The configuration logic downstream decodes its fields from that bus. For example, register 0 carries the 16-bit integer value in bits [30:15] and the 12-bit fraction in bits [14:3].

Top module: `cfg_serial_bank`

## Requirements
- R1: On each rising edge of the synchronised serial clock, the serial data bit is shifted in as the new least significant bit. The word that is latched is the last 32 bits shifted in, so any earlier bits are discarded.
- R2: A rising edge on `ser_le` at the input pins writes the shifted word. The active outputs show the write after exactly three rising edges of `clk`.
- R3: A word whose bits [2:0] are 000, 011 or 101 replaces active register 0, 3 or 5 in full at once.
- R4: A word whose bits [2:0] are 110 or 111 is ignored, and no active register or shadow changes.
- R5: A word with bits [2:0] = 001 goes only to shadow storage, and active register 1 is unchanged until the next register 0 write.
- R6: A word with bits [2:0] = 010 updates active register 2 bits [31:26] and [13:0] at once. Bits [25:14] (reference divider, halve enable and doubler enable) go only to shadow storage.
- R7: A word with bits [2:0] = 100 updates all of active register 4 at once except bits [22:20]. Bits [22:20] are updated at once only if active register 2 bit 13 is 0 at that moment. If that bit is 1, they are held.
- R8: A register 0 write loads active register 0 and, in the same clock, copies the latest register 1 word, the latest register 2 bits [25:14] and the latest register 4 bits [22:20] into the active registers.
- R9: `commit_pulse` is high for exactly one clock per register 0 write, in the clock in which the active outputs change.
- R10: A synchronous active-high `rst` clears all active registers, all shadows and the serial state to zero, with `commit_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Latch strobe; its rising edge writes the word |
| active_regs | output | 192 | Active register i in bits [32*i+31:32*i] |
| commit_pulse | output | 1 | One-clock pulse when a register 0 write releases held fields |

## Verification
Two functions fall in the same clock: the load of register 0's own word and the release of every held field. The bench provokes this by first writing register 1, register 2 with its hold bit set, and register 4 with a new divider value, and only then writing register 0. A reference model, compared on every clock, expects all four words and the commit pulse to change together in one exact cycle. A second pass clears the hold bit before register 4 is written. It then checks that the divider field moved at once, and that the later commit does not bring back an older value.

// File: rtl/cfgbank_pkg.sv
`timescale 1ns/1ps
package cfgbank_pkg;

    localparam int WORD_W   = 32;
    localparam int SEL_W    = 3;
    localparam int NUM_REGS = 6;
    localparam int ODIV_LO  = 20;
    localparam int ODIV_W   = 3;
    localparam int HOLD_BIT = 13;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_FREQ   = 3'd0,
        SEL_MODPH  = 3'd1,
        SEL_REFCFG = 3'd2,
        SEL_AUX3   = 3'd3,
        SEL_OUTCFG = 3'd4,
        SEL_AUX5   = 3'd5,
        SEL_NONE6  = 3'd6,
        SEL_NONE7  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic [SEL_W-1:0] sel;
        word_t            data;
    } latch_t;

    localparam word_t REF_HELD_MASK = 32'h03FF_C000;
    localparam word_t ODIV_MASK     = word_t'(((1 << ODIV_W) - 1) << ODIV_LO);

    function automatic word_t merge_bits(input word_t base, input word_t ins, input word_t mask);
        return (base & ~mask) | (ins & mask);
    endfunction

    function automatic logic sel_known(input logic [SEL_W-1:0] sel);
        return (int'(sel) < NUM_REGS);
    endfunction

endpackage

// File: rtl/cfgbank_sync.sv
`timescale 1ns/1ps
module cfgbank_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= '0;
        else     chain_q[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[i] <= '0;
                else     chain_q[i] <= chain_q[i-1];
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cfgbank_shifter.sv
`timescale 1ns/1ps
module cfgbank_shifter
    import cfgbank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_s,
    input  logic   sdat_s,
    input  logic   le_s,
    output latch_t lat
);
    logic  sclk_d, le_d;
    word_t shift_q;
    logic  sclk_rise, le_rise;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign le_rise   = le_s & ~le_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            le_d    <= 1'b0;
            shift_q <= '0;
        end else begin
            sclk_d <= sclk_s;
            le_d   <= le_s;
            if (sclk_rise)
                shift_q <= {shift_q[WORD_W-2:0], sdat_s};
        end
    end

    always_comb begin
        lat.valid = le_rise;
        lat.sel   = shift_q[SEL_W-1:0];
        lat.data  = shift_q;
    end

    // R1: a rising serial clock moves the sampled data bit into the LSB
    a_r1_shift_lsb: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> shift_q[0] == $past(sdat_s));

    // R2: a latch strobe never lasts two clocks
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        lat.valid |=> !lat.valid);
endmodule

// File: rtl/cfgbank_store.sv
`timescale 1ns/1ps
module cfgbank_store
    import cfgbank_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  latch_t                         lat,
    output logic [NUM_REGS-1:0][WORD_W-1:0] act,
    output logic                           commit
);
    logic [NUM_REGS-1:0][WORD_W-1:0] act_q;
    word_t                           sh_modph;
    word_t                           sh_ref;
    logic [ODIV_W-1:0]               sh_odiv;
    logic                            commit_q;
    logic                            hold_odiv;
    word_t                           odiv_word;

    assign hold_odiv = act_q[SEL_REFCFG][HOLD_BIT];
    assign odiv_word = word_t'({sh_odiv, {ODIV_LO{1'b0}}});

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= '0;
            sh_modph <= '0;
            sh_ref   <= '0;
            sh_odiv  <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (lat.valid && sel_known(lat.sel)) begin
                case (reg_sel_e'(lat.sel))
                    SEL_FREQ: begin
                        act_q[SEL_FREQ]   <= lat.data;
                        act_q[SEL_MODPH]  <= sh_modph;
                        act_q[SEL_REFCFG] <= merge_bits(act_q[SEL_REFCFG], sh_ref, REF_HELD_MASK);
                        act_q[SEL_OUTCFG] <= merge_bits(act_q[SEL_OUTCFG], odiv_word, ODIV_MASK);
                        commit_q          <= 1'b1;
                    end
                    SEL_MODPH:  sh_modph <= lat.data;
                    SEL_REFCFG: begin
                        sh_ref            <= lat.data;
                        act_q[SEL_REFCFG] <= merge_bits(lat.data, act_q[SEL_REFCFG], REF_HELD_MASK);
                    end
                    SEL_AUX3:   act_q[SEL_AUX3] <= lat.data;
                    SEL_OUTCFG: begin
                        sh_odiv <= lat.data[ODIV_LO +: ODIV_W];
                        if (hold_odiv)
                            act_q[SEL_OUTCFG] <= merge_bits(lat.data, act_q[SEL_OUTCFG], ODIV_MASK);
                        else
                            act_q[SEL_OUTCFG] <= lat.data;
                    end
                    SEL_AUX5:   act_q[SEL_AUX5] <= lat.data;
                    default: ;
                endcase
            end
        end
    end

    assign act    = act_q;
    assign commit = commit_q;

    // R3: immediate registers take the whole word
    a_r3_immediate: assert property (@(posedge clk) disable iff (rst)
        (lat.valid && lat.sel == 3'd3) |=> act_q[SEL_AUX3] == $past(lat.data));

    // R4: unused codes leave every active register alone
    a_r4_bad_code_ignored: assert property (@(posedge clk) disable iff (rst)
        (lat.valid && !sel_known(lat.sel)) |=> $stable(act_q));

    // R5: register 1 writes do not reach the active copy
    a_r5_modph_held: assert property (@(posedge clk) disable iff (rst)
        (lat.valid && lat.sel == 3'd1) |=> $stable(act_q[SEL_MODPH]));

    // R6: held reference bits stay put on a register 2 write
    a_r6_ref_held: assert property (@(posedge clk) disable iff (rst)
        (lat.valid && lat.sel == 3'd2) |=> $stable(act_q[SEL_REFCFG] & REF_HELD_MASK));

    // R7: divider field held while the hold bit is set
    a_r7_odiv_held: assert property (@(posedge clk) disable iff (rst)
        (lat.valid && lat.sel == 3'd4 && hold_odiv) |=> $stable(act_q[SEL_OUTCFG] & ODIV_MASK));

    // R9: commit follows each register 0 write and lasts one clock
    a_r9_commit_follows: assert property (@(posedge clk) disable iff (rst)
        (lat.valid && lat.sel == 3'd0) |=> commit_q);
    a_r9_commit_once: assert property (@(posedge clk) disable iff (rst)
        commit_q |=> !commit_q);
endmodule

// File: rtl/cfg_serial_bank.sv
`timescale 1ns/1ps
module cfg_serial_bank
    import cfgbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ser_clk,
    input  logic                         ser_data,
    input  logic                         ser_le,
    output logic [NUM_REGS*WORD_W-1:0]   active_regs,
    output logic                         commit_pulse
);
    localparam int PIN_W = 3;

    logic [PIN_W-1:0]                 pins_s;
    latch_t                           lat;
    logic [NUM_REGS-1:0][WORD_W-1:0]  act;

    cfgbank_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_le, ser_data, ser_clk}),
        .q   (pins_s)
    );

    cfgbank_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (pins_s[0]),
        .sdat_s (pins_s[1]),
        .le_s   (pins_s[2]),
        .lat    (lat)
    );

    cfgbank_store u_store (
        .clk    (clk),
        .rst    (rst),
        .lat    (lat),
        .act    (act),
        .commit (commit_pulse)
    );

    assign active_regs = act;

    // R10: reset leaves the outputs cleared on the next clock
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (active_regs == '0 && !commit_pulse));
endmodule

// File: tb/sim_cfg_serial_bank.sv
`timescale 1ns/1ps
module sim_cfg_serial_bank;

    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_clk = 1'b0;
    logic         ser_data = 1'b0;
    logic         ser_le = 1'b0;
    logic [191:0] active_regs;
    logic         commit_pulse;

    always #10 clk = ~clk;

    cfg_serial_bank u0 (
        .clk          (clk),
        .rst          (rst),
        .ser_clk      (ser_clk),
        .ser_data     (ser_data),
        .ser_le       (ser_le),
        .active_regs  (active_regs),
        .commit_pulse (commit_pulse)
    );

    typedef struct {
        int unsigned at;
        logic [31:0] w;
    } pend_t;

    pend_t       pend[$];
    logic [31:0] m [6];
    logic [31:0] hold1, hold2;
    logic [2:0]  hold4;
    logic        exp_commit;
    int unsigned pe = 0;
    int          nchk = 0, nfail = 0;
    int          commits_seen = 0, commits_exp = 0;
    bit          cmp_on = 0;
    bit          done = 0;

    always @(posedge clk) pe <= pe + 1;

    function automatic logic [31:0] outw(input int i);
        return active_regs[i*32 +: 32];
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 6; i++) m[i] = '0;
        hold1 = '0; hold2 = '0; hold4 = '0;
    endtask

    task automatic model_apply(input logic [31:0] w);
        case (w[2:0])
            3'd0: begin
                m[0] = w;
                m[1] = hold1;
                m[2][25:14] = hold2[25:14];
                m[4][22:20] = hold4;
                exp_commit = 1'b1;
                commits_exp++;
            end
            3'd1: hold1 = w;
            3'd2: begin
                hold2 = w;
                m[2][31:26] = w[31:26];
                m[2][13:0]  = w[13:0];
            end
            3'd3: m[3] = w;
            3'd4: begin
                hold4 = w[22:20];
                if (m[2][13]) begin
                    m[4][31:23] = w[31:23];
                    m[4][19:0]  = w[19:0];
                end else begin
                    m[4] = w;
                end
            end
            3'd5: m[5] = w;
            default: ;
        endcase
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0: return "R2 R3 R8 word0";
            1: return "R5 R8 word1";
            2: return "R6 R8 word2";
            3: return "R1 R3 word3";
            4: return "R7 R8 word4";
            default: return "R3 R4 word5";
        endcase
    endfunction

    // cycle-by-cycle reference comparison
    always @(negedge clk) begin
        exp_commit = 1'b0;
        if (rst) begin
            model_clear();
            pend.delete();
        end else begin
            while (pend.size() > 0 && pend[0].at <= pe) begin
                model_apply(pend[0].w);
                void'(pend.pop_front());
            end
        end
        if (commit_pulse === 1'b1) commits_seen++;
        if (cmp_on) begin
            for (int i = 0; i < 6; i++) begin
                nchk++;
                if (outw(i) !== m[i]) begin
                    nfail++;
                    $display("FAIL %s at cycle %0d: got %h expected %h", tag_of(i), pe, outw(i), m[i]);
                end
            end
            nchk++;
            if (commit_pulse !== exp_commit) begin
                nfail++;
                $display("FAIL R9 commit_pulse at cycle %0d: got %b expected %b", pe, commit_pulse, exp_commit);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            step(2);
            ser_clk = 1'b1;
            step(2);
            ser_clk = 1'b0;
            step(1);
        end
    endtask

    task automatic strobe(input logic [31:0] w);
        pend_t p;
        p.at = pe + LAT;
        p.w  = w;
        ser_le = 1'b1;
        pend.push_back(p);
        step(2);
        ser_le = 1'b0;
        step(4);
    endtask

    task automatic write_word(input logic [31:0] w);
        send_bits({32'd0, w}, 32);
        strobe(w);
    endtask

    task automatic check_eq(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(2);
    endtask

    initial begin
        logic [31:0] snap [6];
        step(1);
        cmp_on = 1;
        do_reset();

        // R10: reset state
        for (int i = 0; i < 6; i++) check_eq("R10 reset word", outw(i), 32'h0);
        check_eq("R10 reset commit", {31'd0, commit_pulse}, 32'h0);

        // R3: immediate registers
        write_word(32'hA5A5_A5A3);
        write_word(32'h1234_5675);
        check_eq("R3 word3", outw(3), 32'hA5A5_A5A3);
        check_eq("R3 word5", outw(5), 32'h1234_5675);

        // R1: extra leading bits are discarded
        send_bits({24'd0, 8'hFF, 32'h0F0F_0F0B}, 40);
        strobe(32'h0F0F_0F0B);
        check_eq("R1 last 32 bits", outw(3), 32'h0F0F_0F0B);

        // R4: unused codes 110 and 111
        for (int i = 0; i < 6; i++) snap[i] = outw(i);
        write_word(32'hFFFF_FFFE);
        write_word(32'hFFFF_FFFF);
        for (int i = 0; i < 6; i++) check_eq("R4 unused code", outw(i), snap[i]);

        // R5: register 1 held
        write_word(32'h0ABC_D129);
        check_eq("R5 word1 held", outw(1), 32'h0);

        // R6: reference bits held, hold bit 13 set at once
        write_word(32'h03FF_E002);
        check_eq("R6 word2 partial", outw(2), 32'h0000_2002);

        // R7: divider field held while bit 13 is set
        write_word(32'h0050_0A04);
        check_eq("R7 held divider", outw(4), 32'h0000_0A04);

        // R8 / R9: register 0 releases all in one clock
        write_word(32'h4000_8008);
        check_eq("R8 word0", outw(0), 32'h4000_8008);
        check_eq("R8 word1", outw(1), 32'h0ABC_D129);
        check_eq("R8 word2", outw(2), 32'h03FF_E002);
        check_eq("R8 word4", outw(4), 32'h0050_0A04);
        check_eq("R9 one pulse", commits_seen, 1);

        // R7: hold bit clear -> divider immediate
        write_word(32'h0000_0002);
        check_eq("R6 held after clear", outw(2), 32'h03FF_C002);
        write_word(32'h0030_0004);
        check_eq("R7 immediate divider", outw(4), 32'h0030_0004);

        // R8: commit releases latest shadows, no stale divider
        write_word(32'h0001_0000);
        check_eq("R8 word2 released", outw(2), 32'h0000_0002);
        check_eq("R8 word4 kept", outw(4), 32'h0030_0004);
        check_eq("R9 pulses match", commits_seen, commits_exp);

        // R10: reset in mid-run
        do_reset();
        for (int i = 0; i < 6; i++) check_eq("R10 mid-run reset", outw(i), 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule